// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small, fully associative cache of address translations. A requester presents an address-space identifier, a virtual page number, the page offset and the kind of access. In the same cycle every stored entry is compared against that key. The block then answers with hit or miss, the translated physical address and a fault flag. The page offset is not translated; it is placed next to the cached physical page number.

Each entry holds the following fields:
- the physical page number;
- a read-only or read/write rights bit;
- dirty and reference bits;
- a valid bit;
- the identifier of the address space that owns it;
- a global bit, which makes the entry match under every identifier.

Because the identifier is part of the tag, translations from many processes can sit in the cache together, and a context switch needs no flush.

On a miss the block reports only the miss. Some agent outside the block walks the tables and writes the answer back through the fill port. A round-robin pointer picks the victim for each fill. A single mapping can be removed by virtual page and identifier, and the whole cache can be emptied in one cycle.

Top module: `tlb_fa`

## Requirements
- R1: After reset no entry is valid, so every lookup misses, and the replacement pointer starts at entry 0.
- R2: An accepted lookup hits when a valid entry has an equal virtual page number and an equal identifier. The physical address is then the entry's page number concatenated above the request offset (the offset in the low 12 bits). On a miss, `lk_hit_o` and `lk_fault_o` are both 0.
- R3: An entry filled with the global bit set hits for its virtual page under every identifier value.
- R4: Entries with the same virtual page number and different identifiers coexist, and each returns its own physical page number.
- R5: A write lookup (`lk_write_i`=1) that hits raises `lk_fault_o` unless the entry has both read/write rights (`fill_rw_i`=1) and dirty set. A read lookup never raises the fault.
- R6: `lk_ref_o` shows the reference bit stored in the hit entry before this lookup. An accepted hit sets that bit, and the next lookup of the same entry shows it as 1.
- R7: A fill that matches no entry is written at the replacement pointer, which then advances by one and wraps after the last entry. With N entries, fill N+1 replaces the entry written by fill 1.
- R8: A fill whose key matches a valid entry overwrites that entry in place and leaves the replacement pointer unchanged.
- R9: An invalidate clears every valid entry that would hit for its page number and identifier. Global entries of that page are included. No other entry is touched.
- R10: Flush clears every entry. While flush is high, `fill_ready_o` and `lk_ready_o` are 0, and the lookup in the cycle after a flush misses.
- R11: `lk_ready_o` is 0 in any cycle where fill, invalidate or flush is asserted. A lookup offered in such a cycle reports no hit and does not change any reference bit. When a fill and an invalidate of the same key come in one cycle, the fill's entry survives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid_i | input | 1 | Lookup request present |
| lk_ready_o | output | 1 | Lookup accepted this cycle when high |
| lk_asid_i | input | ASID_W | Lookup address-space identifier |
| lk_vpn_i | input | VPN_W | Lookup virtual page number |
| lk_off_i | input | OFF_W | Page offset, passed through |
| lk_write_i | input | 1 | 1 for a write access, 0 for a read |
| lk_hit_o | output | 1 | Accepted lookup hit |
| lk_pa_o | output | PPN_W+OFF_W | Translated physical address |
| lk_fault_o | output | 1 | Write denied by rights or clean dirty bit |
| lk_ref_o | output | 1 | Stored reference bit of the hit entry |
| lk_dirty_o | output | 1 | Stored dirty bit of the hit entry |
| fill_valid_i | input | 1 | Fill request present |
| fill_ready_o | output | 1 | Fill accepted this cycle when high |
| fill_asid_i | input | ASID_W | Fill identifier |
| fill_vpn_i | input | VPN_W | Fill virtual page number |
| fill_ppn_i | input | PPN_W | Fill physical page number |
| fill_rw_i | input | 1 | 1 for read/write rights, 0 for read-only |
| fill_dirty_i | input | 1 | Initial dirty bit |
| fill_ref_i | input | 1 | Initial reference bit |
| fill_global_i | input | 1 | Entry matches under any identifier |
| inv_valid_i | input | 1 | Invalidate one mapping |
| inv_asid_i | input | ASID_W | Invalidate identifier |
| inv_vpn_i | input | VPN_W | Invalidate virtual page number |
| flush_i | input | 1 | Clear every entry |

## Verification
Two operations can land in the same cycle, and the bench provokes both cases on purpose.

The first is a lookup offered while a fill is being written. The bench drives both in one cycle and checks three things: `lk_ready_o` is low, no hit is reported, and a later clean lookup of the target entry still shows its reference bit as 0.

The second is a fill and an invalidate of the same key in one cycle. The bench judges this by a lookup on the next cycle, which must hit with the filled page number.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int DEF_ASID_W = 6;
  localparam int DEF_VPN_W  = 20;
  localparam int DEF_OFF_W  = 12;

  typedef enum logic {
    RIGHTS_RO = 1'b0,
    RIGHTS_RW = 1'b1
  } rights_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N  = 64,
  parameter int AW = 6,
  parameter int VW = 20
) (
  input  logic [N-1:0]         ent_valid_i,
  input  logic [N-1:0]         ent_glob_i,
  input  logic [N-1:0][AW-1:0] ent_asid_i,
  input  logic [N-1:0][VW-1:0] ent_vpn_i,
  input  logic [AW-1:0]        key_asid_i,
  input  logic [VW-1:0]        key_vpn_i,
  output logic [N-1:0]         hits_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hits_o[g] = ent_valid_i[g] && (ent_vpn_i[g] == key_vpn_i) &&
                       (ent_glob_i[g] || (ent_asid_i[g] == key_asid_i));
  end
endmodule

// File: rtl/tlb_rr.sv
module tlb_rr #(
  parameter int N  = 64,
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_i,
  output logic [IW-1:0] ptr_o
);
  logic [IW-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     ptr_q <= '0;
    else if (adv_i) ptr_q <= (ptr_q == IW'(N-1)) ? '0 : ptr_q + 1'b1;
  end
  assign ptr_o = ptr_q;

  // R7: pointer stays inside the array
  p_ptr_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_o <= IW'(N-1));

  // R7: each allocation moves the pointer one step, wrapping at the end
  p_ptr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i |=> (ptr_o == (($past(ptr_o) == IW'(N-1)) ? '0 : $past(ptr_o) + 1'b1)));

  // R8: without an allocation the pointer holds
  p_ptr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(ptr_o));
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int ASID_W  = DEF_ASID_W,
  parameter int VPN_W   = DEF_VPN_W,
  parameter int PPN_W   = 20,
  parameter int OFF_W   = DEF_OFF_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lk_valid_i,
  output logic                   lk_ready_o,
  input  logic [ASID_W-1:0]      lk_asid_i,
  input  logic [VPN_W-1:0]       lk_vpn_i,
  input  logic [OFF_W-1:0]       lk_off_i,
  input  logic                   lk_write_i,
  output logic                   lk_hit_o,
  output logic [PPN_W+OFF_W-1:0] lk_pa_o,
  output logic                   lk_fault_o,
  output logic                   lk_ref_o,
  output logic                   lk_dirty_o,
  input  logic                   fill_valid_i,
  output logic                   fill_ready_o,
  input  logic [ASID_W-1:0]      fill_asid_i,
  input  logic [VPN_W-1:0]       fill_vpn_i,
  input  logic [PPN_W-1:0]       fill_ppn_i,
  input  logic                   fill_rw_i,
  input  logic                   fill_dirty_i,
  input  logic                   fill_ref_i,
  input  logic                   fill_global_i,
  input  logic                   inv_valid_i,
  input  logic [ASID_W-1:0]      inv_asid_i,
  input  logic [VPN_W-1:0]       inv_vpn_i,
  input  logic                   flush_i
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]              valid_q, glob_q, dirty_q, ref_q;
  rights_e                         rights_q [ENTRIES];
  logic [ENTRIES-1:0][ASID_W-1:0]  asid_q;
  logic [ENTRIES-1:0][VPN_W-1:0]   vpn_q;
  logic [ENTRIES-1:0][PPN_W-1:0]   ppn_q;

  logic [ENTRIES-1:0] lk_hits, fill_hits, inv_hits;
  logic [IDX_W-1:0]   rr_ptr, dup_idx, fill_idx;
  logic               lk_go, fill_go, fill_dup, any_hit;
  logic [PPN_W-1:0]   sel_ppn;
  rights_e            sel_rights;
  logic               sel_dirty, sel_ref;

  // Three parallel comparators: lookup, fill duplicate check, invalidate
  tlb_match #(.N(ENTRIES), .AW(ASID_W), .VW(VPN_W)) u_lk_match (
    .ent_valid_i(valid_q), .ent_glob_i(glob_q), .ent_asid_i(asid_q), .ent_vpn_i(vpn_q),
    .key_asid_i(lk_asid_i), .key_vpn_i(lk_vpn_i), .hits_o(lk_hits));

  tlb_match #(.N(ENTRIES), .AW(ASID_W), .VW(VPN_W)) u_fill_match (
    .ent_valid_i(valid_q), .ent_glob_i(glob_q), .ent_asid_i(asid_q), .ent_vpn_i(vpn_q),
    .key_asid_i(fill_asid_i), .key_vpn_i(fill_vpn_i), .hits_o(fill_hits));

  tlb_match #(.N(ENTRIES), .AW(ASID_W), .VW(VPN_W)) u_inv_match (
    .ent_valid_i(valid_q), .ent_glob_i(glob_q), .ent_asid_i(asid_q), .ent_vpn_i(vpn_q),
    .key_asid_i(inv_asid_i), .key_vpn_i(inv_vpn_i), .hits_o(inv_hits));

  assign lk_ready_o   = !(fill_valid_i || inv_valid_i || flush_i);
  assign fill_ready_o = !flush_i;
  assign lk_go        = lk_valid_i && lk_ready_o;
  assign fill_go      = fill_valid_i && fill_ready_o;
  assign fill_dup     = |fill_hits;
  assign any_hit      = |lk_hits;

  // Read mux over the hit vector; lowest index wins if several match
  always_comb begin
    sel_ppn    = '0;
    sel_rights = RIGHTS_RO;
    sel_dirty  = 1'b0;
    sel_ref    = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lk_hits[i]) begin
        sel_ppn    = ppn_q[i];
        sel_rights = rights_q[i];
        sel_dirty  = dirty_q[i];
        sel_ref    = ref_q[i];
      end
    end
  end

  // Fill target: an existing copy of the key, else the round-robin victim
  always_comb begin
    dup_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (fill_hits[i]) dup_idx = IDX_W'(i);
    end
  end
  assign fill_idx = fill_dup ? dup_idx : rr_ptr;

  tlb_rr #(.N(ENTRIES), .IW(IDX_W)) u_rr (
    .clk(clk), .rst_n(rst_n), .adv_i(fill_go && !fill_dup), .ptr_o(rr_ptr));

  assign lk_hit_o   = lk_go && any_hit;
  assign lk_pa_o    = {sel_ppn, lk_off_i};
  assign lk_fault_o = lk_hit_o && lk_write_i && !((sel_rights == RIGHTS_RW) && sel_dirty);
  assign lk_ref_o   = lk_hit_o && sel_ref;
  assign lk_dirty_o = lk_hit_o && sel_dirty;

  // Entry state; invalidate and reference updates come first, the fill write last
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      glob_q  <= '0;
      dirty_q <= '0;
      ref_q   <= '0;
      asid_q  <= '0;
      vpn_q   <= '0;
      ppn_q   <= '0;
      for (int i = 0; i < ENTRIES; i++) rights_q[i] <= RIGHTS_RO;
    end else if (flush_i) begin
      valid_q <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (inv_valid_i && inv_hits[i]) valid_q[i] <= 1'b0;
        if (lk_go && lk_hits[i])        ref_q[i]   <= 1'b1;
      end
      if (fill_go) begin
        valid_q[fill_idx]  <= 1'b1;
        glob_q[fill_idx]   <= fill_global_i;
        dirty_q[fill_idx]  <= fill_dirty_i;
        ref_q[fill_idx]    <= fill_ref_i;
        asid_q[fill_idx]   <= fill_asid_i;
        vpn_q[fill_idx]    <= fill_vpn_i;
        ppn_q[fill_idx]    <= fill_ppn_i;
        rights_q[fill_idx] <= fill_rw_i ? RIGHTS_RW : RIGHTS_RO;
      end
    end
  end

  // R10: nothing can hit in the cycle right after a flush
  p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !lk_hit_o);

  // R5: a fault only comes from a write that hit
  p_fault_on_write_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault_o |-> (lk_hit_o && lk_write_i));

  // R11: a lookup that collides with maintenance or a fill never hits
  p_stall_no_hit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid_i && (fill_valid_i || inv_valid_i || flush_i)) |-> !lk_hit_o);
endmodule

// File: tb/tlb_fa_test.sv
module tlb_fa_test;
  localparam int N  = 8;
  localparam int AW = 6;
  localparam int VW = 20;
  localparam int PW = 20;
  localparam int OW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          lk_valid = 0, lk_write = 0;
  logic [AW-1:0] lk_asid = '0;
  logic [VW-1:0] lk_vpn = '0;
  logic [OW-1:0] lk_off = '0;
  logic          lk_ready, lk_hit, lk_fault, lk_ref, lk_dirty;
  logic [PW+OW-1:0] lk_pa;
  logic          fill_valid = 0, fill_rw = 0, fill_dirty = 0, fill_ref = 0, fill_glob = 0;
  logic [AW-1:0] fill_asid = '0;
  logic [VW-1:0] fill_vpn = '0;
  logic [PW-1:0] fill_ppn = '0;
  logic          fill_ready;
  logic          inv_valid = 0, flush = 0;
  logic [AW-1:0] inv_asid = '0;
  logic [VW-1:0] inv_vpn = '0;

  tlb_fa #(.ENTRIES(N), .ASID_W(AW), .VPN_W(VW), .PPN_W(PW), .OFF_W(OW)) uut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid_i(lk_valid), .lk_ready_o(lk_ready), .lk_asid_i(lk_asid), .lk_vpn_i(lk_vpn),
    .lk_off_i(lk_off), .lk_write_i(lk_write), .lk_hit_o(lk_hit), .lk_pa_o(lk_pa),
    .lk_fault_o(lk_fault), .lk_ref_o(lk_ref), .lk_dirty_o(lk_dirty),
    .fill_valid_i(fill_valid), .fill_ready_o(fill_ready), .fill_asid_i(fill_asid),
    .fill_vpn_i(fill_vpn), .fill_ppn_i(fill_ppn), .fill_rw_i(fill_rw),
    .fill_dirty_i(fill_dirty), .fill_ref_i(fill_ref), .fill_global_i(fill_glob),
    .inv_valid_i(inv_valid), .inv_asid_i(inv_asid), .inv_vpn_i(inv_vpn), .flush_i(flush));

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic r_hit, r_fault, r_ref, r_rdy;
  logic [PW+OW-1:0] r_pa;

  function automatic logic [PW-1:0] ppn_of(int i);
    return PW'(i * 37 + 5);
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_fill(int asid, int vpn, int ppn, bit rw, bit dt, bit rf, bit gl);
    fill_asid = AW'(asid); fill_vpn = VW'(vpn); fill_ppn = PW'(ppn);
    fill_rw = rw; fill_dirty = dt; fill_ref = rf; fill_glob = gl; fill_valid = 1;
  endtask

  task automatic do_fill(int asid, int vpn, int ppn, bit rw, bit dt, bit rf, bit gl);
    set_fill(asid, vpn, ppn, rw, dt, rf, gl);
    tick;
    fill_valid = 0;
  endtask

  task automatic do_inv(int asid, int vpn);
    inv_asid = AW'(asid); inv_vpn = VW'(vpn); inv_valid = 1;
    tick;
    inv_valid = 0;
  endtask

  task automatic set_look(int asid, int vpn, int off, bit wr);
    lk_asid = AW'(asid); lk_vpn = VW'(vpn); lk_off = OW'(off); lk_write = wr; lk_valid = 1;
  endtask

  task automatic look(int asid, int vpn, int off, bit wr);
    set_look(asid, vpn, off, wr);
    #1;
    r_hit = lk_hit; r_pa = lk_pa; r_fault = lk_fault; r_ref = lk_ref; r_rdy = lk_ready;
    tick;
    lk_valid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: empty after reset
    look(0, 0, 0, 0);
    check(r_hit == 0, "R1", "hit after reset", r_hit, 0);
    check(r_rdy == 1, "R1", "ready after reset", r_rdy, 1);

    // R2/R5/R6: fill all entries, then sweep lookups
    for (int i = 0; i < N; i++)
      do_fill(i, i * 3 + 1, ppn_of(i), i[0], i[1], 0, 0);
    for (int i = 0; i < N; i++) begin
      look(i, i * 3 + 1, i * 100, 0);
      check(r_hit == 1, "R2", "hit", r_hit, 1);
      check(r_pa == {ppn_of(i), OW'(i * 100)}, "R2", "pa", r_pa, {ppn_of(i), OW'(i * 100)});
      check(r_fault == 0, "R5", "read fault", r_fault, 0);
      check(r_ref == 0, "R6", "ref first", r_ref, 0);
      look(i, i * 3 + 1, 0, 0);
      check(r_ref == 1, "R6", "ref second", r_ref, 1);
      look(i + 8, i * 3 + 1, 0, 0);
      check(r_hit == 0 && r_fault == 0, "R2", "other asid miss", r_hit, 0);
      look(i, i * 3 + 1, 0, 1);
      check(r_hit == 1, "R5", "write hit", r_hit, 1);
      check(r_fault == !(i[0] && i[1]), "R5", "write fault", r_fault, !(i[0] && i[1]));
    end

    // R7: wrap-around replaces entry 0
    do_fill(9, 1, 'h777, 1, 1, 0, 0);
    look(0, 1, 0, 0);
    check(r_hit == 0, "R7", "oldest replaced", r_hit, 0);
    look(1, 4, 0, 0);
    check(r_hit == 1, "R7", "second still present", r_hit, 1);
    // R4: same VPN, two ASIDs
    do_fill(10, 1, 'h888, 1, 1, 0, 0);
    look(9, 1, 0, 0);
    check(r_pa[OW +: PW] == 'h777, "R4", "asid9 ppn", r_pa[OW +: PW], 'h777);
    look(10, 1, 0, 0);
    check(r_pa[OW +: PW] == 'h888, "R4", "asid10 ppn", r_pa[OW +: PW], 'h888);
    look(1, 4, 0, 0);
    check(r_hit == 0, "R7", "entry 1 replaced", r_hit, 0);
    // R8: overwrite in place, pointer stays at entry 2
    do_fill(9, 1, 'h999, 1, 1, 0, 0);
    look(9, 1, 0, 0);
    check(r_pa[OW +: PW] == 'h999, "R8", "overwritten ppn", r_pa[OW +: PW], 'h999);
    do_fill(20, 'h40, 'h444, 1, 1, 0, 0);
    look(2, 7, 0, 0);
    check(r_hit == 0, "R8", "entry 2 is next victim", r_hit, 0);
    look(3, 10, 0, 0);
    check(r_hit == 1, "R8", "entry 3 untouched", r_hit, 1);
    look(10, 1, 0, 0);
    check(r_hit == 1, "R8", "no duplicate consumed slot", r_hit, 1);

    // R10: flush, with ready behaviour during it
    flush = 1;
    #1;
    check(fill_ready == 0, "R10", "fill_ready in flush", fill_ready, 0);
    check(lk_ready == 0, "R10", "lk_ready in flush", lk_ready, 0);
    tick;
    flush = 0;
    look(3, 10, 0, 0);
    check(r_hit == 0, "R10", "after flush", r_hit, 0);

    // R3: a global entry hits under every ASID
    do_fill(0, 'h50, 'h123, 1, 1, 0, 1);
    for (int a = 0; a < 64; a++) begin
      look(a, 'h50, a, 0);
      check(r_hit == 1 && r_pa == {PW'('h123), OW'(a)}, "R3", "global hit", r_pa, {PW'('h123), OW'(a)});
    end

    // R9: single invalidation
    do_fill(5, 'h60, 'h605, 1, 1, 0, 0);
    do_fill(6, 'h60, 'h606, 1, 1, 0, 0);
    do_inv(5, 'h60);
    look(5, 'h60, 0, 0);
    check(r_hit == 0, "R9", "invalidated", r_hit, 0);
    look(6, 'h60, 0, 0);
    check(r_hit == 1 && r_pa[OW +: PW] == 'h606, "R9", "neighbour kept", r_pa[OW +: PW], 'h606);
    do_inv(7, 'h50);
    look(3, 'h50, 0, 0);
    check(r_hit == 0, "R9", "global invalidated", r_hit, 0);

    // R11: lookup collides with a fill
    do_fill(2, 'h80, 'h800, 1, 1, 0, 0);
    set_fill(1, 'h70, 'h700, 1, 1, 0, 0);
    set_look(2, 'h80, 0, 0);
    #1;
    check(lk_ready == 0, "R11", "ready during fill", lk_ready, 0);
    check(lk_hit == 0, "R11", "no hit during fill", lk_hit, 0);
    tick;
    fill_valid = 0; lk_valid = 0;
    look(2, 'h80, 0, 0);
    check(r_hit == 1 && r_ref == 0, "R11", "stalled lookup left ref", r_ref, 0);
    // R11: fill and invalidate of one key in one cycle
    set_fill(4, 'h90, 'h900, 1, 1, 0, 0);
    inv_asid = 4; inv_vpn = 'h90; inv_valid = 1;
    tick;
    fill_valid = 0; inv_valid = 0;
    look(4, 'h90, 0, 0);
    check(r_hit == 1 && r_pa[OW +: PW] == 'h900, "R11", "fill wins", r_pa[OW +: PW], 'h900);

    // R10: flush clears everything
    flush = 1;
    tick;
    flush = 0;
    look(2, 'h80, 0, 0);
    check(r_hit == 0, "R10", "flushed a", r_hit, 0);
    look(4, 'h90, 0, 0);
    check(r_hit == 0, "R10", "flushed b", r_hit, 0);
    look(6, 'h60, 0, 0);
    check(r_hit == 0, "R10", "flushed c", r_hit, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule